// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block tracks atomic read-modify-write reservations for a small group of processor contexts sharing one memory. A context opens a reservation with a locked load, and the monitor remembers the physical address and raises that context's reservation flag. A later conditional store from the same context is allowed to reach memory only if the flag is still up and the store hits the same 16-byte granule. Any store that does reach memory drops every reservation, held by any context, on the granule it writes.

Requests arrive one per cycle on a valid/ready channel. Each request carries a context number, an address, a request kind and an uncacheable flag. One cycle later the monitor reports a result code and a write-permit that the memory path uses to let the store through or cancel it. The monitor also counts consecutive failed conditional stores for each context. When a context's run of failures reaches a multiple of a set period, the monitor emits a one-cycle livelock warning carrying that context's number.

Top module: `llsc_monitor`

## Requirements
- R1: Once reset is released, `req_ready` is 1 and a request is accepted on every rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in exactly the cycle that follows an accepted request.
- R2: Kind encoding is 0 for a plain load, 1 for a locked load, 2 for a plain store and 3 for a conditional store. A locked load sets the context's reservation flag and records the address. A cacheable conditional store from the same context then succeeds if address bits above bit 3 match. Success returns result 1 with write permit 1.
- R3: A cacheable conditional store fails if the context's flag is clear or the granule differs. A failure returns result 0 with write permit 0 and clears that context's flag, so a retry to the originally reserved address also fails.
- R4: An uncacheable conditional store (`req_uncached`=1, kind 3) skips the reservation check and returns result 2 with write permit 1. Like any store that writes, it also clears matching reservations.
- R5: Every request that writes memory (a plain store, a successful conditional store or an uncacheable conditional store) clears the flag of every context whose reserved granule equals the written granule. Reservations on other granules stay intact. A plain store returns result 0 with write permit 1.
- R6: A plain load changes no reservation and returns result 0 with write permit 0.
- R7: For each context, the monitor counts consecutive failed cacheable conditional stores in a saturating counter. A successful or uncacheable conditional store from that context resets the count to zero. Each time the count reaches a multiple of `WARN_PERIOD` (default 100000), `warn_pulse` is 1 for one cycle, together with the response, and `warn_ctx` holds the context number.
- R8: After reset, no context holds a reservation, `rsp_valid` and `warn_pulse` are 0, and every failure count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Monitor accepts a request this cycle |
| req_ctx | input | CTX_W | Requesting context number |
| req_addr | input | ADDR_W | Physical address |
| req_kind | input | 2 | 0 load, 1 locked load, 2 store, 3 conditional store |
| req_uncached | input | 1 | Request targets uncacheable space |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_result | output | 2 | 0 fail/none, 1 conditional success, 2 uncacheable conditional |
| rsp_write_ok | output | 1 | Memory write may proceed |
| warn_pulse | output | 1 | Livelock warning, one cycle |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
The bench runs a conditional store at an address that differs from the reservation only below bit 4, which separates granule comparison from exact-address comparison. It runs another one bit 4 away, which catches a granule mask that is too wide. Cross-context sequences put several reservations on one granule and one reservation on a different granule, then store from a fourth context. The outcome shows whether the clearing is selective, and whether it covers all contexts or only the requester. The failure-run patterns break a run with a success and, separately, with an uncacheable store, and they check that the warning fires exactly on the period boundary and not one request early or late. A held-valid pair of requests shows that back-to-back acceptance works and that the reservation set by the first request is visible to the second.

// File: rtl/llsc_pkg.sv
// Shared encodings for the reservation monitor: request kinds and result codes.
package llsc_pkg;
    localparam logic [1:0] KIND_LOAD       = 2'd0;
    localparam logic [1:0] KIND_LOCK_LOAD  = 2'd1;
    localparam logic [1:0] KIND_STORE      = 2'd2;
    localparam logic [1:0] KIND_COND_STORE = 2'd3;

    localparam logic [1:0] RES_NONE     = 2'd0;
    localparam logic [1:0] RES_PASS     = 2'd1;
    localparam logic [1:0] RES_UNCACHED = 2'd2;
endpackage

// File: rtl/llsc_resv_slot.sv
// One context's reservation: a flag and the reserved address.
// A snooped write to the same granule drops the flag, and so does an own
// failed conditional store. A set from a locked load wins over any clear in
// the same cycle (clear first, then set).
// Assumes GRAN_BITS < ADDR_W.
module llsc_resv_slot #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              snoop_en,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              drop_en,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);
    logic snoop_hit;

    // Granule match between the stored reservation and the address being written.
    always_comb begin
        snoop_hit = snoop_en && held &&
                    (held_addr[ADDR_W-1:GRAN_BITS] == snoop_addr[ADDR_W-1:GRAN_BITS]);
    end

    // Reservation state update, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            held_addr <= '0;
        end else if (set_en) begin
            held      <= 1'b1;
            held_addr <= set_addr;
        end else if (snoop_hit || drop_en) begin
            held      <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_fail_track.sv
// Consecutive-failure tracker for one context. It keeps a saturating count of
// failed conditional stores and a modulo counter that wraps at PERIOD, so
// "count reached a multiple of PERIOD" needs no divider. warn is a registered
// one-cycle pulse. Assumes PERIOD >= 2.
module llsc_fail_track #(
    parameter int CNT_W  = 32,
    parameter int PERIOD = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_en,
    input  logic clear_en,
    output logic warn
);
    localparam int MOD_W = $clog2(PERIOD);
    localparam logic [MOD_W-1:0] MOD_LAST = MOD_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [CNT_W-1:0] run_cnt;
    logic [MOD_W-1:0] mod_cnt;
    logic             saturated;

    // Flags a counter that can no longer reach a new multiple.
    always_comb saturated = (run_cnt == CNT_MAX);

    // Run counter, modulo phase and warning pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            mod_cnt <= '0;
            warn    <= 1'b0;
        end else begin
            warn <= 1'b0;
            if (clear_en) begin
                run_cnt <= '0;
                mod_cnt <= '0;
            end else if (fail_en && !saturated) begin
                run_cnt <= run_cnt + 1'b1;
                if (mod_cnt == MOD_LAST) begin
                    mod_cnt <= '0;
                    warn    <= 1'b1;
                end else begin
                    mod_cnt <= mod_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/llsc_req_decode.sv
// Classifies an accepted request against the requester's own reservation.
// It produces the reservation set, the failure drop, the success and
// uncached events, the memory write permit and the result code.
// Purely combinational. Assumes only one request per cycle.
module llsc_req_decode
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic              accept,
    input  logic [1:0]        kind,
    input  logic              uncached,
    input  logic [ADDR_W-1:0] addr,
    input  logic              own_held,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              ll_set,
    output logic              sc_pass,
    output logic              sc_fail,
    output logic              sc_unc,
    output logic              write_go,
    output logic [1:0]        result
);
    logic is_sc;
    logic gran_eq;

    // Request kind and own-reservation compare.
    always_comb begin
        is_sc   = accept && (kind == KIND_COND_STORE);
        gran_eq = (own_addr[ADDR_W-1:GRAN_BITS] == addr[ADDR_W-1:GRAN_BITS]);
    end

    // Event and result generation.
    always_comb begin
        ll_set   = accept && (kind == KIND_LOCK_LOAD);
        sc_unc   = is_sc && uncached;
        sc_pass  = is_sc && !uncached && own_held && gran_eq;
        sc_fail  = is_sc && !uncached && !(own_held && gran_eq);
        write_go = (accept && (kind == KIND_STORE)) || sc_pass || sc_unc;
        if (sc_unc)       result = RES_UNCACHED;
        else if (sc_pass) result = RES_PASS;
        else              result = RES_NONE;
    end
endmodule

// File: rtl/llsc_monitor.sv
// Reservation monitor top. It holds one reservation slot and one failure
// tracker per context, decodes the single request accepted each cycle and
// registers the response one cycle later. Writes snoop every slot.
// Assumes req_ctx < NUM_CTX. Out-of-range requests are not accepted.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_CTX     = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int FAIL_CNT_W  = 32,
    parameter int WARN_PERIOD = 100000,
    parameter int CTX_W       = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_uncached,
    output logic              rsp_valid,
    output logic [1:0]        rsp_result,
    output logic              rsp_write_ok,
    output logic              warn_pulse,
    output logic [CTX_W-1:0]  warn_ctx
);
    logic              ready_q;
    logic              accept;
    logic [NUM_CTX-1:0] held_vec;
    logic [ADDR_W-1:0] held_addr [NUM_CTX];
    logic [NUM_CTX-1:0] warn_vec;
    logic              own_held;
    logic [ADDR_W-1:0] own_addr;
    logic              ll_set, sc_pass, sc_fail, sc_unc, write_go;
    logic [1:0]        result_d;

    // Ready rises one cycle after reset release and then stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Handshake and selection of the requester's own reservation.
    always_comb begin
        req_ready = ready_q;
        accept    = req_valid && ready_q && (int'(req_ctx) < NUM_CTX);
        own_held  = 1'b0;
        own_addr  = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (int'(req_ctx) == i) begin
                own_held = held_vec[i];
                own_addr = held_addr[i];
            end
        end
    end

    llsc_req_decode #(
        .ADDR_W   (ADDR_W),
        .GRAN_BITS(GRAN_BITS)
    ) u_decode (
        .accept  (accept),
        .kind    (req_kind),
        .uncached(req_uncached),
        .addr    (req_addr),
        .own_held(own_held),
        .own_addr(own_addr),
        .ll_set  (ll_set),
        .sc_pass (sc_pass),
        .sc_fail (sc_fail),
        .sc_unc  (sc_unc),
        .write_go(write_go),
        .result  (result_d)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        logic mine;
        // Marks the slot that belongs to the current requester.
        always_comb mine = (int'(req_ctx) == g);

        llsc_resv_slot #(
            .ADDR_W   (ADDR_W),
            .GRAN_BITS(GRAN_BITS)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_en    (ll_set && mine),
            .set_addr  (req_addr),
            .snoop_en  (write_go),
            .snoop_addr(req_addr),
            .drop_en   (sc_fail && mine),
            .held      (held_vec[g]),
            .held_addr (held_addr[g])
        );

        llsc_fail_track #(
            .CNT_W (FAIL_CNT_W),
            .PERIOD(WARN_PERIOD)
        ) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .fail_en (sc_fail && mine),
            .clear_en((sc_pass || sc_unc) && mine),
            .warn    (warn_vec[g])
        );
    end

    // Response register, one cycle behind acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_result   <= RES_NONE;
            rsp_write_ok <= 1'b0;
        end else begin
            rsp_valid    <= accept;
            rsp_result   <= accept ? result_d : RES_NONE;
            rsp_write_ok <= write_go;
        end
    end

    // Warning merge: at most one tracker fires per cycle.
    always_comb begin
        warn_pulse = |warn_vec;
        warn_ctx   = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (warn_vec[i]) warn_ctx = CTX_W'(i);
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Protocol and state checks for the reservation monitor, bound to the top.
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [CTX_W-1:0]   req_ctx,
    input logic [1:0]         req_kind,
    input logic               req_uncached,
    input logic               rsp_valid,
    input logic [1:0]         rsp_result,
    input logic               rsp_write_ok,
    input logic               warn_pulse,
    input logic [NUM_CTX-1:0] held_vec
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid && req_ready));

    assert_ll_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready && req_kind == KIND_LOCK_LOAD)
        |-> held_vec[$past(req_ctx)]);

    assert_fail_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_result == RES_NONE && $past(req_kind) == KIND_COND_STORE)
        |-> !rsp_write_ok);

    assert_unc_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind == KIND_COND_STORE && req_uncached))
        |-> (rsp_result == RES_UNCACHED && rsp_write_ok));

    assert_store_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == KIND_STORE)
        |-> (rsp_write_ok && rsp_result == RES_NONE));

    assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == KIND_LOAD)
        |-> (!rsp_write_ok && rsp_result == RES_NONE));

    assert_warn_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> $past(req_valid && req_ready &&
                             req_kind == KIND_COND_STORE && !req_uncached));
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .NUM_CTX(NUM_CTX),
    .CTX_W  (CTX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_ctx     (req_ctx),
    .req_kind    (req_kind),
    .req_uncached(req_uncached),
    .rsp_valid   (rsp_valid),
    .rsp_result  (rsp_result),
    .rsp_write_ok(rsp_write_ok),
    .warn_pulse  (warn_pulse),
    .held_vec    (held_vec)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
    localparam int NCTX   = 4;
    localparam int AW     = 32;
    localparam int CW     = 2;
    localparam int PERIOD = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_ctx = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_uncached = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_result;
    logic          rsp_write_ok;
    logic          warn_pulse;
    logic [CW-1:0] warn_ctx;

    int n_checks = 0;
    int n_bad    = 0;

    always #4 clk = ~clk;

    llsc_monitor #(
        .NUM_CTX    (NCTX),
        .ADDR_W     (AW),
        .WARN_PERIOD(PERIOD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_addr(req_addr), .req_kind(req_kind),
        .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
        .rsp_write_ok(rsp_write_ok), .warn_pulse(warn_pulse), .warn_ctx(warn_ctx)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One request: drive at a falling edge, sample the response at the next one.
    task automatic req(input int ctx, input int kind, input logic [AW-1:0] addr,
                       input logic unc);
        @(negedge clk);
        req_valid = 1'b1;
        req_ctx = CW'(ctx);
        req_kind = 2'(kind);
        req_addr = addr;
        req_uncached = unc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input int res, input int wok);
        check({tag, " valid"}, int'(rsp_valid), 1);
        check({tag, " result"}, int'(rsp_result), res);
        check({tag, " write"}, int'(rsp_write_ok), wok);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R8 rsp_valid after reset", int'(rsp_valid), 0);
        check("R8 warn after reset", int'(warn_pulse), 0);
        check("R1 ready after reset", int'(req_ready), 1);
        req(0, 3, 32'h100, 1'b0);
        expect_rsp("R8 sc with no reservation", 0, 0);
        @(negedge clk);
        check("R1 valid drops when idle", int'(rsp_valid), 0);
    endtask

    task automatic t_ll_sc();
        do_reset();
        req(1, 1, 32'h1000, 1'b0);
        expect_rsp("R6 locked load response", 0, 0);
        req(1, 3, 32'h100C, 1'b0);
        expect_rsp("R2 sc same granule", 1, 1);
        req(1, 3, 32'h1000, 1'b0);
        expect_rsp("R5 own write cleared reservation", 0, 0);
    endtask

    task automatic t_fail();
        do_reset();
        req(0, 1, 32'h2000, 1'b0);
        req(0, 3, 32'h2010, 1'b0);
        expect_rsp("R3 sc next granule", 0, 0);
        req(0, 3, 32'h2000, 1'b0);
        expect_rsp("R3 retry after failure", 0, 0);
    endtask

    task automatic t_uncached();
        do_reset();
        req(2, 3, 32'h3000, 1'b1);
        expect_rsp("R4 uncached sc no reservation", 2, 1);
        req(0, 1, 32'h3004, 1'b0);
        req(2, 3, 32'h3000, 1'b1);
        expect_rsp("R4 uncached sc", 2, 1);
        req(0, 3, 32'h3004, 1'b0);
        expect_rsp("R4 uncached write clears others", 0, 0);
    endtask

    task automatic t_snoop();
        do_reset();
        req(0, 1, 32'h4000, 1'b0);
        req(1, 1, 32'h4008, 1'b0);
        req(2, 1, 32'h5000, 1'b0);
        req(3, 2, 32'h400F, 1'b0);
        expect_rsp("R5 plain store", 0, 1);
        req(0, 3, 32'h4000, 1'b0);
        expect_rsp("R5 ctx0 cleared", 0, 0);
        req(1, 3, 32'h4008, 1'b0);
        expect_rsp("R5 ctx1 cleared", 0, 0);
        req(2, 3, 32'h5000, 1'b0);
        expect_rsp("R5 other granule kept", 1, 1);
        req(0, 1, 32'h6000, 1'b0);
        req(1, 1, 32'h6004, 1'b0);
        req(0, 3, 32'h6000, 1'b0);
        expect_rsp("R5 sc success", 1, 1);
        req(1, 3, 32'h6004, 1'b0);
        expect_rsp("R5 success clears peer", 0, 0);
    endtask

    task automatic t_load();
        do_reset();
        req(1, 1, 32'h7000, 1'b0);
        req(0, 0, 32'h7000, 1'b0);
        expect_rsp("R6 peer load", 0, 0);
        req(1, 0, 32'h7000, 1'b0);
        expect_rsp("R6 own load", 0, 0);
        req(1, 3, 32'h7000, 1'b0);
        expect_rsp("R6 reservation survives loads", 1, 1);
    endtask

    task automatic t_back_to_back();
        do_reset();
        @(negedge clk);
        req_valid = 1'b1; req_ctx = 2'd0; req_kind = 2'd1;
        req_addr = 32'h8000; req_uncached = 1'b0;
        @(negedge clk);
        expect_rsp("R1 first of pair", 0, 0);
        req_kind = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R1 second of pair", 1, 1);
        @(negedge clk);
        check("R1 valid after pair", int'(rsp_valid), 0);
    endtask

    task automatic fail_run(input int n, input string tag);
        for (int i = 1; i <= n; i++) begin
            req(3, 3, 32'h9000, 1'b0);
            check({tag, " early no warn"}, int'(warn_pulse), 0);
        end
    endtask

    task automatic t_warn();
        do_reset();
        fail_run(PERIOD - 1, "R7 first run");
        req(3, 3, 32'h9000, 1'b0);
        check("R7 warn at period", int'(warn_pulse), 1);
        check("R7 warn ctx", int'(warn_ctx), 3);
        @(negedge clk);
        check("R7 pulse one cycle", int'(warn_pulse), 0);
        req(3, 3, 32'h9000, 1'b0);
        check("R7 no warn past period", int'(warn_pulse), 0);
        req(3, 1, 32'h9000, 1'b0);
        req(3, 3, 32'h9000, 1'b0);
        expect_rsp("R7 success resets", 1, 1);
        fail_run(PERIOD - 1, "R7 after success");
        req(3, 3, 32'h9000, 1'b0);
        check("R7 warn after success reset", int'(warn_pulse), 1);
        req(3, 3, 32'h9000, 1'b1);
        fail_run(PERIOD - 1, "R7 after uncached");
        req(3, 3, 32'h9000, 1'b0);
        check("R7 warn after uncached reset", int'(warn_pulse), 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_ll_sc();
        t_fail();
        t_uncached();
        t_snoop();
        t_load();
        t_back_to_back();
        t_warn();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule